// File: doc/BRIEF.md
# Machine-Cycle Status and Port Bus Sequencer

This block runs the external bus of an 8-bit processor core that has a 16-bit address bus and a separate space of 256 I/O ports. The core asks for one machine cycle at a time. It gives the cycle kind, an address or port number, and the write data. The sequencer then runs the cycle on the bus pins in a fixed order. In the first state it drives the address, puts a status byte on the data lines and raises a one-cycle sync pulse, so that outside logic can latch that byte. In the next state the read or write strobe comes up and the ready input is sampled. Each time ready is low, one wait state is added. A final transfer state ends the cycle.

The status byte tells outside logic what kind of cycle follows. It shows memory or port, read or write, opcode fetch, interrupt acknowledge, halt acknowledge and stack traffic. The stack bit lets a board decode a separate stack memory. For a port cycle the 8-bit port number is copied onto both bytes of the address bus. Read data is registered at the end of the transfer state and handed back to the core with a one-cycle done pulse.

Top module: `mcycle_bus_seq`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `done` is 0, `bus_sync`, `bus_rd`, `bus_wr` and `bus_doe` are 0, and `bus_addr` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle (T1), `bus_sync` is 1 for exactly that one cycle, `bus_doe` is 1 and `bus_dout` carries the status byte.
- R3: `req_kind` codes are 0 fetch, 1 memory read, 2 memory write, 3 stack read, 4 stack write, 5 port input, 6 port output, 7 interrupt acknowledge, 8 halt acknowledge. Codes 9 to 15 behave as code 8. The status bits are: bit0 interrupt acknowledge, bit1 not-write, bit2 stack, bit3 halt acknowledge, bit4 port output, bit5 opcode fetch, bit6 port input, bit7 memory read. This gives 0xA2, 0x82, 0x00, 0x86, 0x04, 0x42, 0x10, 0x23 and 0x8A for codes 0 to 8.
- R4: Status bit 2 is 1 only for stack read and stack write cycles.
- R5: For port cycles (codes 5 and 6), `bus_addr` is `{req_addr[7:0], req_addr[7:0]}`. For every other kind it is `req_addr` unchanged. The address is valid from T1 to the end of the cycle.
- R6: The read strobe `bus_rd` is high from T2 through T3 for codes 0, 1, 3, 5 and 7. The write strobe `bus_wr` is high over the same span for codes 2, 4 and 6. Code 8 raises neither strobe, and the two strobes are never high together.
- R7: `bus_ready` is sampled in T2 and in each wait state. Each sample that finds it low adds one wait state. During a wait state the address and both strobes hold their values. With no waits a cycle takes T1, T2 and T3.
- R8: `bus_din` is captured at the clock edge that ends T3 for read kinds. In the cycle after T3, `done` is 1 for exactly one cycle, `rdata` holds the captured byte and `req_ready` is 1.
- R9: For write kinds, `bus_doe` is 1 and `bus_dout` carries the write data from T2 through T3.
- R10: `req_valid` is ignored while a cycle is in progress. A request raised and dropped before the cycle ends starts no cycle, and it does not change the address on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 4 | Cycle kind code |
| req_addr | input | ADDR_W | Memory address, or port number in bits 7:0 |
| req_wdata | input | DATA_W | Data for write cycles |
| req_ready | output | 1 | Sequencer idle, able to accept a request |
| done | output | 1 | One-cycle pulse after the transfer state |
| rdata | output | DATA_W | Byte captured during a read cycle |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | Data bus output: status in T1, write data later |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data bus input |
| bus_sync | output | 1 | Marks the status byte in T1 |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ready | input | 1 | Device ready; low inserts wait states |

## Verification
The end of one cycle and the start of the next meet in the idle cycle. There, the done pulse and the returned read data for one cycle coincide with acceptance of the next request. The bench sets up this collision by presenting a new request in the very cycle that `done` is high. It then checks that the finished read data is still correct, and that the next clock produces the new sync pulse, status byte and address with no idle gap. It also raises and drops a request in the middle of a cycle with wait states. It confirms that neither the bus address nor the next cycle start is disturbed.

// File: rtl/busseq_pkg.sv
// Package: shared types and cycle-kind helpers for the bus sequencer.
// Assumes an 8-bit status byte and at most 16 cycle-kind codes.
package busseq_pkg;

    // Kind of machine cycle requested by the core.
    typedef enum logic [3:0] {
        CK_FETCH   = 4'd0,
        CK_MEM_RD  = 4'd1,
        CK_MEM_WR  = 4'd2,
        CK_STK_RD  = 4'd3,
        CK_STK_WR  = 4'd4,
        CK_PORT_IN = 4'd5,
        CK_PORT_OUT= 4'd6,
        CK_INT_ACK = 4'd7,
        CK_HALT_ACK= 4'd8
    } cyc_kind_e;

    // Bus state: T1 status, T2 ready sample, TW wait, T3 transfer.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_TW   = 3'd3,
        S_T3   = 3'd4
    } bus_state_e;

    // Status byte bit positions (decoded by outside logic).
    localparam int unsigned SB_INTA  = 0;
    localparam int unsigned SB_WRN   = 1;
    localparam int unsigned SB_STACK = 2;
    localparam int unsigned SB_HLTA  = 3;
    localparam int unsigned SB_OUT   = 4;
    localparam int unsigned SB_M1    = 5;
    localparam int unsigned SB_INP   = 6;
    localparam int unsigned SB_MEMR  = 7;
    localparam int unsigned STATUS_W = 8;

    // True for kinds whose data moves from the bus into the core.
    function automatic logic kind_reads(cyc_kind_e k);
        return (k == CK_FETCH) || (k == CK_MEM_RD) || (k == CK_STK_RD) ||
               (k == CK_PORT_IN) || (k == CK_INT_ACK);
    endfunction

    // True for kinds whose data moves from the core onto the bus.
    function automatic logic kind_writes(cyc_kind_e k);
        return (k == CK_MEM_WR) || (k == CK_STK_WR) || (k == CK_PORT_OUT);
    endfunction

    // True for cycles addressed into the port space.
    function automatic logic kind_is_port(cyc_kind_e k);
        return (k == CK_PORT_IN) || (k == CK_PORT_OUT);
    endfunction

endpackage

// File: rtl/busseq_status_enc.sv
// Module: builds the status byte for a cycle kind.
// Assumes the kind has already been normalised to a defined code.
module busseq_status_enc
    import busseq_pkg::*;
(
    input  cyc_kind_e                 kind_i,
    output logic [STATUS_W-1:0]       status_o
);

    // Set the status flags that belong to each cycle kind.
    always_comb begin
        status_o = '0;
        unique case (kind_i)
            CK_FETCH: begin
                status_o[SB_MEMR] = 1'b1;
                status_o[SB_M1]   = 1'b1;
                status_o[SB_WRN]  = 1'b1;
            end
            CK_MEM_RD: begin
                status_o[SB_MEMR] = 1'b1;
                status_o[SB_WRN]  = 1'b1;
            end
            CK_MEM_WR: begin
                status_o = '0;
            end
            CK_STK_RD: begin
                status_o[SB_MEMR]  = 1'b1;
                status_o[SB_STACK] = 1'b1;
                status_o[SB_WRN]   = 1'b1;
            end
            CK_STK_WR: begin
                status_o[SB_STACK] = 1'b1;
            end
            CK_PORT_IN: begin
                status_o[SB_INP] = 1'b1;
                status_o[SB_WRN] = 1'b1;
            end
            CK_PORT_OUT: begin
                status_o[SB_OUT] = 1'b1;
            end
            CK_INT_ACK: begin
                status_o[SB_INTA] = 1'b1;
                status_o[SB_M1]   = 1'b1;
                status_o[SB_WRN]  = 1'b1;
            end
            default: begin
                status_o[SB_HLTA] = 1'b1;
                status_o[SB_MEMR] = 1'b1;
                status_o[SB_WRN]  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/busseq_addr_mux.sv
// Module: chooses the bus address. Port cycles copy the port number
// into every PORT_W-wide slice of the address; memory cycles pass through.
// Assumes ADDR_W >= PORT_W. Leftover top bits of a port address are zero.
module busseq_addr_mux #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PORT_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_port_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned REP = ADDR_W / PORT_W;

    logic [ADDR_W-1:0] mirrored;

    // Copy the port number into each slice of the address.
    for (genvar g = 0; g < REP; g++) begin : g_rep
        assign mirrored[g*PORT_W +: PORT_W] = addr_i[PORT_W-1:0];
    end

    // Clear any top bits that do not fill a whole slice.
    if (ADDR_W > REP*PORT_W) begin : g_tail
        assign mirrored[ADDR_W-1:REP*PORT_W] = '0;
    end

    // Choose between the copied port address and the plain address.
    assign addr_o = is_port_i ? mirrored : addr_i;

endmodule

// File: rtl/busseq_fsm.sv
// Module: machine-cycle state machine. Accepts one request while idle,
// steps T1 -> T2 -> (TW)* -> T3, latches the request, captures read data
// and pulses done. Assumes the core holds no second request outstanding.
module busseq_fsm
    import busseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_din,
    output bus_state_e        st_o,
    output cyc_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);

    bus_state_e        st;
    cyc_kind_e         kind_q;
    cyc_kind_e         kind_n;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              accept;

    // Map undefined kind codes onto halt acknowledge.
    always_comb begin
        if (req_kind > 4'd8) kind_n = CK_HALT_ACK;
        else                 kind_n = cyc_kind_e'(req_kind);
    end

    assign req_ready = (st == S_IDLE);
    assign accept    = req_ready && req_valid;

    // Advance the bus state; ready decides between waiting and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:     if (accept) st <= S_T1;
                S_T1:       st <= S_T2;
                S_T2, S_TW: st <= bus_ready ? S_T3 : S_TW;
                S_T3:       st <= S_IDLE;
                default:    st <= S_IDLE;
            endcase
        end
    end

    // Latch the request so it stays fixed for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= kind_n;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture input data at the end of the transfer state of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if ((st == S_T3) && kind_reads(kind_q)) begin
            rdata_q <= bus_din;
        end
    end

    // Pulse done for the one cycle that follows the transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (st == S_T3);
    end

    assign st_o    = st;
    assign kind_o  = kind_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;
    assign done_o  = done_q;

    AST_LATCH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(addr_q) && $stable(kind_q)); // R10

    AST_DONE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

    AST_DONE_FOLLOWS_T3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_T3) |=> (st == S_IDLE) && done_q); // R8

endmodule

// File: rtl/mcycle_bus_seq.sv
// Module: top of the machine-cycle bus sequencer. Drives the status byte
// with a sync pulse in T1, the address from T1 onwards, the read or write
// strobe from T2 to T3, and inserts wait states while ready is low.
// Assumes a single-driver bus: bus_doe gates the data outputs externally.
module mcycle_bus_seq
    import busseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_sync,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready
);

    bus_state_e          st;
    cyc_kind_e           kind;
    logic [ADDR_W-1:0]   lat_addr;
    logic [DATA_W-1:0]   lat_wdata;
    logic [STATUS_W-1:0] status_b;
    logic [DATA_W-1:0]   status_ext;
    logic                in_t1;
    logic                in_xfer;

    busseq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .bus_ready (bus_ready),
        .bus_din   (bus_din),
        .st_o      (st),
        .kind_o    (kind),
        .addr_o    (lat_addr),
        .wdata_o   (lat_wdata),
        .rdata_o   (rdata),
        .done_o    (done)
    );

    busseq_status_enc u_status (
        .kind_i   (kind),
        .status_o (status_b)
    );

    busseq_addr_mux #(
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W)
    ) u_addr (
        .addr_i    (lat_addr),
        .is_port_i (kind_is_port(kind)),
        .addr_o    (bus_addr)
    );

    // Decode the state into the status phase and the strobe phase.
    assign in_t1   = (st == S_T1);
    assign in_xfer = (st == S_T2) || (st == S_TW) || (st == S_T3);

    // Widen the status byte to the data bus width.
    assign status_ext = DATA_W'(status_b);

    // Drive the bus pins: status in T1, strobes and write data afterwards.
    always_comb begin
        bus_sync = in_t1;
        bus_rd   = in_xfer && kind_reads(kind);
        bus_wr   = in_xfer && kind_writes(kind);
        bus_doe  = in_t1 || (in_xfer && kind_writes(kind));
        bus_dout = in_t1 ? status_ext : lat_wdata;
    end

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync |=> !bus_sync); // R2

    AST_SYNC_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync |-> bus_doe && !bus_rd && !bus_wr); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R6

    AST_ADDR_FROM_T1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync |=> $stable(bus_addr)); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TW) |-> $stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr)); // R7

endmodule

// File: tb/mcycle_bus_seq_bench.sv
`timescale 1ns/1ps
module mcycle_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        done;
    logic [7:0]  rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [7:0]  bus_din;
    logic        bus_sync;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mcycle_bus_seq u_mcycle_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_sync(bus_sync),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Status byte per kind, from R3.
    function automatic logic [7:0] exp_status(input logic [3:0] k);
        case (k)
            4'd0: return 8'hA2;
            4'd1: return 8'h82;
            4'd2: return 8'h00;
            4'd3: return 8'h86;
            4'd4: return 8'h04;
            4'd5: return 8'h42;
            4'd6: return 8'h10;
            4'd7: return 8'h23;
            default: return 8'h8A;
        endcase
    endfunction

    function automatic bit exp_rd(input logic [3:0] k);
        return k == 0 || k == 1 || k == 3 || k == 5 || k == 7;
    endfunction

    function automatic bit exp_wr(input logic [3:0] k);
        return k == 2 || k == 4 || k == 6;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [3:0] k, input logic [15:0] a);
        return (k == 5 || k == 6) ? {a[7:0], a[7:0]} : a;
    endfunction

    // One machine cycle; starts at a negedge, ends at the negedge of the done cycle.
    // With poke set, a foreign request is raised in T2 and dropped in T3.
    task automatic do_cycle(input logic [3:0] k, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rv,
                            input int waits, input bit poke);
        logic [15:0] ea = exp_addr(k, a);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        @(posedge clk);
        for (int c = 0; c <= waits + 3; c++) begin
            @(negedge clk);
            if (c == 0) begin
                req_valid = 1'b0;
                chk(bus_sync == 1'b1, "R2 sync in T1", bus_sync, 1);
                chk(bus_doe == 1'b1 && bus_dout == exp_status(k), "R3 status byte",
                    bus_dout, exp_status(k));
                chk(bus_dout[2] == (k == 3 || k == 4), "R4 stack bit", bus_dout[2],
                    (k == 3 || k == 4));
                chk(bus_addr == ea, "R5 address in T1", bus_addr, ea);
                chk(!bus_rd && !bus_wr, "R6 no strobe in T1", {bus_rd, bus_wr}, 0);
            end else if (c <= waits + 2) begin
                chk(bus_sync == 1'b0, "R2 sync single", bus_sync, 0);
                chk(bus_rd == exp_rd(k), "R6 read strobe", bus_rd, exp_rd(k));
                chk(bus_wr == exp_wr(k), "R6 write strobe", bus_wr, exp_wr(k));
                chk(bus_addr == ea, "R7 address held", bus_addr, ea);
                chk(done == 1'b0, "R7 no early done", done, 0);
                if (exp_wr(k))
                    chk(bus_doe && bus_dout == wd, "R9 write data", bus_dout, wd);
                if (poke && c == 1) begin
                    req_valid = 1'b1; req_kind = 4'd6; req_addr = ~a;
                end
                if (poke && c == waits + 2) req_valid = 1'b0;
            end else begin
                chk(done == 1'b1, "R8 done pulse", done, 1);
                chk(req_ready == 1'b1, "R8 ready after cycle", req_ready, 1);
                chk(!bus_rd && !bus_wr, "R6 strobes released", {bus_rd, bus_wr}, 0);
                if (exp_rd(k)) chk(rdata == rv, "R8 read data", rdata, rv);
            end
            bus_ready = !(c >= 1 && c <= waits);
            bus_din   = (c == waits + 2) ? rv : ~rv;
        end
    endtask

    task automatic idle_cycle;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 4'd0; req_addr = '0;
        req_wdata = '0; bus_din = '0; bus_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done, "R1 reset handshake", {req_ready, done}, 2'b10);
        chk(!bus_sync && !bus_rd && !bus_wr && !bus_doe, "R1 reset pins",
            {bus_sync, bus_rd, bus_wr, bus_doe}, 0);
        chk(bus_addr == 16'h0, "R1 reset address", bus_addr, 0);
    endtask

    task automatic t_all_kinds;
        for (int k = 0; k <= 8; k++) begin
            do_cycle(4'(k), 16'h3C5A + 16'(k * 16'h0111), 8'h5A ^ 8'(k), 8'hC3 ^ 8'(k), 0, 1'b0);
            idle_cycle();
        end
        do_cycle(4'd12, 16'h1234, 8'h00, 8'h77, 0, 1'b0); // R3 undefined code acts as halt ack
        idle_cycle();
    endtask

    task automatic t_waits;
        do_cycle(4'd1, 16'hBEEF, 8'h00, 8'h9D, 1, 1'b0);   // R7 one wait
        idle_cycle();
        do_cycle(4'd6, 16'h00F3, 8'hE1, 8'h00, 4, 1'b0);   // R7 and R9 during waits
        idle_cycle();
        do_cycle(4'd5, 16'h7781, 8'h00, 8'h4B, 3, 1'b0);   // R5 port mirror with waits
        idle_cycle();
    endtask

    task automatic t_busy_ignore;
        do_cycle(4'd3, 16'hA55A, 8'h00, 8'h66, 2, 1'b1);
        @(negedge clk);
        chk(bus_sync == 1'b0, "R10 no stray cycle", bus_sync, 0);
        chk(bus_addr == 16'hA55A, "R10 address kept", bus_addr, 16'hA55A);
        idle_cycle();
    endtask

    task automatic t_back_to_back;
        do_cycle(4'd0, 16'h0100, 8'h00, 8'h3E, 0, 1'b0);
        do_cycle(4'd4, 16'hFFFE, 8'hD2, 8'h00, 1, 1'b0); // R2 new T1 right after done
        do_cycle(4'd7, 16'h0038, 8'h00, 8'hFF, 0, 1'b0);
        idle_cycle();
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_all_kinds();
        t_waits();
        t_busy_ignore();
        t_back_to_back();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule